// File: doc/BRIEF.md
# Parallel ADC conversion sequencer

This block is the digital control side of a successive-approximation converter with a parallel result port. A falling edge on the active-low start input freezes the value on the sample port and starts a conversion. The conversion lasts a fixed number of master-clock ticks, set by the result width. While it runs, the busy flag is high. When the last tick arrives, the held sample is loaded into the result register. Busy drops one system clock after that load.

The master clock is given as a one-cycle enable pulse, `mclk_tick`, in the system clock domain. The result is put on a parallel bus only while both active-low select inputs are low. The two selects are combined by a plain AND, so either one can act as the read strobe. If the start input is still low when the conversion finishes, the block goes to sleep. A later rising edge of the start input begins a wake-up delay, counted in system clocks. New conversions are refused until that delay has run out.

Top module: `adc_seq_top`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `sleeping` and `bus_oe` are low, and `result` and `bus_q` are zero.
- R2: In the idle state, a start level that is high on one clock edge and low on the next is a falling edge. It is accepted even if the low level lasts a single clock. `busy` is high from the clock after that edge. `sample_in` is captured at that same edge, so later changes to `sample_in` do not affect the result.
- R3: The master-clock ticks that count toward a conversion are those on the clock edges after the start edge. With CONV_CYCLES = RES_W + 2 (14 for 12 bits, 12 for 10 bits), the result is loaded on the edge that carries the CONV_CYCLES-th such tick. `busy` goes low one clock later.
- R4: `result` changes only while `busy` is high. The new value is already present in the clock cycle before `busy` falls.
- R5: A start falling edge while `busy` is high is ignored. The conversion in progress keeps its timing and its captured sample.
- R6: If the start input is low on the edge where `busy` falls, `sleeping` rises on that same edge. If it is high, the block returns to idle and `sleeping` stays low.
- R7: While asleep, a rising start edge begins a wake-up period. `sleeping` goes low exactly WAKE_CLKS clocks after that edge. Start falling edges during the wake-up period are ignored, and the first falling edge after it starts a conversion.
- R8: `bus_oe` is a register that goes high one clock after `cs_n` and `rd_n` are both low. It goes low one clock after either of them is high. While `bus_oe` is low, `bus_q` is zero.
- R9: While `bus_oe` is high, `bus_q` follows `result` with no register delay. With both selects held low, the new result appears on the bus before `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low conversion start strobe |
| mclk_tick | input | 1 | Master conversion clock, one system-clock pulse per tick |
| cs_n | input | 1 | Active-low select, ANDed with `rd_n` |
| rd_n | input | 1 | Active-low read, ANDed with `cs_n` |
| sample_in | input | RES_W | Digital value standing in for the analog input |
| busy | output | 1 | High while a conversion is in progress |
| sleeping | output | 1 | High while asleep or waking up |
| result | output | RES_W | Output register holding the last conversion |
| bus_oe | output | 1 | Parallel bus drive enable |
| bus_q | output | RES_W | Parallel bus data, zero when released |

## Verification
Conversions are run three ways:
- With a tick on every clock, which pins down the exact load edge and the busy-fall edge.
- With ticks every second or third clock, which shows that only ticks advance the count, not system clocks.
- With an extra start falling edge inserted mid-conversion and `sample_in` changed at the same time, which separates an ignored edge from a restart or a recapture.

The start level at the end of a conversion is run both high and low, to tell the return to idle from sleep entry. The wake-up window is then probed with a start edge that must be refused, and a later one that must be accepted. The select pair is driven in all its combinations to show the AND behaviour and the one-clock enable delay.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    SQ_TRACK = 3'd0,
    SQ_CONV  = 3'd1,
    SQ_FIN   = 3'd2,
    SQ_SLEEP = 3'd3,
    SQ_WAKE  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/adc_seq_edge.sv
// Registers the start strobe once and reports its edges against the live level.
module adc_seq_edge (
  input  logic clk,
  input  logic rst,
  input  logic start_n,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= start_n;
  end

  assign fall = prev_q & ~start_n;
  assign rise = ~prev_q & start_n;
endmodule

// File: rtl/adc_seq_counter.sv
// Counts advance pulses; last is high on the advance that completes LIMIT of them.
module adc_seq_counter #(
  parameter int LIMIT = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic last
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (adv)   cnt_q <= cnt_q + W'(1);
  end

  assign last = adv && (cnt_q == LAST_VAL);
endmodule

// File: rtl/adc_seq_fsm.sv
// Sequencing state machine: track, convert, finish, sleep, wake.
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_fall,
  input  logic start_rise,
  input  logic start_lvl_n,
  input  logic mclk_tick,
  input  logic conv_last,
  input  logic wake_last,
  output logic conv_adv,
  output logic conv_clr,
  output logic wake_adv,
  output logic wake_clr,
  output logic capture,
  output logic load,
  output logic busy,
  output logic sleeping
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    load    = 1'b0;
    case (state_q)
      SQ_TRACK: if (start_fall) begin
        capture = 1'b1;
        state_d = SQ_CONV;
      end
      SQ_CONV: if (conv_last) begin
        load    = 1'b1;
        state_d = SQ_FIN;
      end
      SQ_FIN:   state_d = start_lvl_n ? SQ_TRACK : SQ_SLEEP;
      SQ_SLEEP: if (start_rise) state_d = SQ_WAKE;
      SQ_WAKE:  if (wake_last) state_d = SQ_TRACK;
      default:  state_d = SQ_TRACK;
    endcase
  end

  assign conv_adv = (state_q == SQ_CONV) && mclk_tick;
  assign conv_clr = (state_q != SQ_CONV);
  assign wake_adv = (state_q == SQ_WAKE);
  assign wake_clr = (state_q != SQ_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_TRACK;
      busy     <= 1'b0;
      sleeping <= 1'b0;
    end else begin
      state_q  <= state_d;
      busy     <= (state_d == SQ_CONV) || (state_d == SQ_FIN);
      sleeping <= (state_d == SQ_SLEEP) || (state_d == SQ_WAKE);
    end
  end
endmodule

// File: rtl/adc_seq_out.sv
// Sample hold, result register and gated parallel bus.
module adc_seq_out #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RES_W-1:0] sample_in,
  input  logic             capture,
  input  logic             load,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [RES_W-1:0] result,
  output logic             bus_oe,
  output logic [RES_W-1:0] bus_q
);
  logic [RES_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      result <= '0;
      bus_oe <= 1'b0;
    end else begin
      if (capture) hold_q <= sample_in;
      if (load)    result <= hold_q;
      bus_oe <= ~(cs_n | rd_n);
    end
  end

  assign bus_q = bus_oe ? result : '0;
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int RES_W     = 12,
  parameter int WAKE_CLKS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             mclk_tick,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [RES_W-1:0] sample_in,
  output logic             busy,
  output logic             sleeping,
  output logic [RES_W-1:0] result,
  output logic             bus_oe,
  output logic [RES_W-1:0] bus_q
);
  localparam int CONV_CYCLES = RES_W + 2;

  logic start_fall, start_rise;
  logic conv_adv, conv_clr, conv_last;
  logic wake_adv, wake_clr, wake_last;
  logic capture, load;

  adc_seq_edge u_edge (
    .clk(clk), .rst(rst), .start_n(start_n),
    .fall(start_fall), .rise(start_rise)
  );

  adc_seq_counter #(.LIMIT(CONV_CYCLES)) u_conv_cnt (
    .clk(clk), .rst(rst), .clr(conv_clr), .adv(conv_adv), .last(conv_last)
  );

  adc_seq_counter #(.LIMIT(WAKE_CLKS)) u_wake_cnt (
    .clk(clk), .rst(rst), .clr(wake_clr), .adv(wake_adv), .last(wake_last)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rst(rst),
    .start_fall(start_fall), .start_rise(start_rise), .start_lvl_n(start_n),
    .mclk_tick(mclk_tick), .conv_last(conv_last), .wake_last(wake_last),
    .conv_adv(conv_adv), .conv_clr(conv_clr),
    .wake_adv(wake_adv), .wake_clr(wake_clr),
    .capture(capture), .load(load), .busy(busy), .sleeping(sleeping)
  );

  adc_seq_out #(.RES_W(RES_W)) u_out (
    .clk(clk), .rst(rst), .sample_in(sample_in),
    .capture(capture), .load(load), .cs_n(cs_n), .rd_n(rd_n),
    .result(result), .bus_oe(bus_oe), .bus_q(bus_q)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W       = 12,
  parameter int CONV_CYCLES = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             start_n,
  input logic             mclk_tick,
  input logic             cs_n,
  input logic             rd_n,
  input logic             busy,
  input logic             sleeping,
  input logic [RES_W-1:0] result,
  input logic             bus_oe,
  input logic [RES_W-1:0] bus_q
);
  localparam int TW = $clog2(CONV_CYCLES + 2) + 1;

  logic [TW-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) tick_cnt <= '0;
    else              tick_cnt <= tick_cnt + TW'(mclk_tick);
  end

  // R2: busy only rises after the start input was seen low
  p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(start_n));

  // R3: busy lasts CONV_CYCLES ticks, plus at most the finishing clock's tick
  p_conv_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (tick_cnt >= TW'(CONV_CYCLES)) && (tick_cnt <= TW'(CONV_CYCLES + 1)));

  // R4: the result register moves only inside a conversion
  p_result_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> busy);

  // R4: result already settled when busy drops
  p_result_first_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $stable(result));

  // R6: sleep is entered only at the end of a conversion
  p_sleep_entry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sleeping) |-> $fell(busy));

  // R7: no conversion while asleep or waking
  p_no_busy_asleep_r7: assert property (@(posedge clk) disable iff (rst)
    sleeping |-> !busy);

  // R8: enable follows the AND of both selects one clock later
  p_oe_on_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cs_n && !rd_n) |=> bus_oe);

  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && (cs_n || rd_n)) |=> !bus_oe);

  // R8: released bus carries zero
  p_bus_released_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_q == '0));
endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .start_n(start_n), .mclk_tick(mclk_tick),
  .cs_n(cs_n), .rd_n(rd_n), .busy(busy), .sleeping(sleeping),
  .result(result), .bus_oe(bus_oe), .bus_q(bus_q)
);

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 12;
  localparam int WAKE       = 20;
  localparam int CONV       = RES_W + 2;

  logic             clk = 1'b0;
  logic             rst;
  logic             start_n;
  logic             mclk_tick;
  logic             cs_n;
  logic             rd_n;
  logic [RES_W-1:0] sample_in;
  logic             busy;
  logic             sleeping;
  logic [RES_W-1:0] result;
  logic             bus_oe;
  logic [RES_W-1:0] bus_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_top #(.RES_W(RES_W), .WAKE_CLKS(WAKE)) dut (
    .clk(clk), .rst(rst), .start_n(start_n), .mclk_tick(mclk_tick),
    .cs_n(cs_n), .rd_n(rd_n), .sample_in(sample_in),
    .busy(busy), .sleeping(sleeping), .result(result),
    .bus_oe(bus_oe), .bus_q(bus_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; start_n = 1'b1; mclk_tick = 1'b0;
    cs_n = 1'b1; rd_n = 1'b1; sample_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0,     "R1", busy, 0);
    chk(sleeping == 1'b0, "R1", sleeping, 0);
    chk(bus_oe == 1'b0,   "R1", bus_oe, 0);
    chk(result == '0,     "R1", result, 0);
    chk(bus_q == '0,      "R1", bus_q, 0);
  endtask

  // One conversion: tick every 'period' clocks, optional extra start edge mid-conversion.
  task automatic run_conv(input int period, input logic [RES_W-1:0] smp,
                          input bit hold_low, input bit glitch, input bit bus_on);
    logic [RES_W-1:0] prior;
    int  ticks;
    bit  drv_tick, lvl, held_ok, done;
    prior = result;
    lvl = !hold_low;
    sample_in = smp;
    start_n = 1'b0;
    drv_tick = (period == 1);
    mclk_tick = drv_tick;
    ticks = 0; held_ok = 1'b1; done = 1'b0;
    for (int k = 0; k < 400 && !done; k++) begin
      cyc();
      if (k > 0 && drv_tick) ticks++;
      if (ticks < CONV) begin
        if (!(busy && result == prior)) held_ok = 1'b0;
        if (k == 0) sample_in = ~smp;
        start_n = lvl;
        if (glitch && k == 2) start_n = ~lvl;
        drv_tick = ((k + 1) % period == 0);
        mclk_tick = drv_tick;
      end else begin
        chk(busy == 1'b1, "R4", busy, 1);
        chk(result == smp, glitch ? "R5" : "R2", result, smp);
        if (bus_on) chk(bus_q == smp, "R9", bus_q, smp);
        cyc();
        chk(busy == 1'b0, "R3", busy, 0);
        chk(sleeping == hold_low, "R6", sleeping, hold_low);
        done = 1'b1;
      end
    end
    chk(held_ok, glitch ? "R5" : "R3", held_ok, 1);
    chk(done, "R3", done, 1);
  endtask

  task automatic t_bus(input logic [RES_W-1:0] exp);
    cs_n = 1'b0; rd_n = 1'b1; cyc();
    chk(!bus_oe && bus_q == '0, "R8", bus_q, 0);
    cs_n = 1'b1; rd_n = 1'b0; cyc();
    chk(!bus_oe && bus_q == '0, "R8", bus_q, 0);
    cs_n = 1'b0; rd_n = 1'b0;
    chk(!bus_oe, "R8", bus_oe, 0);
    cyc();
    chk(bus_oe && bus_q == exp, "R8", bus_q, exp);
    cs_n = 1'b1; rd_n = 1'b1; cyc();
    chk(!bus_oe && bus_q == '0, "R8", bus_q, 0);
  endtask

  task automatic t_sleep_wake();
    bit ok;
    chk(sleeping && !busy, "R6", sleeping, 1);
    start_n = 1'b1; cyc();
    chk(sleeping == 1'b1, "R7", sleeping, 1);
    start_n = 1'b0;
    ok = 1'b1;
    for (int k = 1; k <= WAKE; k++) begin
      cyc();
      if (busy) ok = 1'b0;
      if (k < WAKE && !sleeping) ok = 1'b0;
      if (k == WAKE) chk(sleeping == 1'b0, "R7", sleeping, 0);
    end
    chk(ok, "R7", ok, 1);
    start_n = 1'b1; mclk_tick = 1'b1; sample_in = 12'h155; cyc();
    start_n = 1'b0; cyc();
    chk(busy == 1'b1, "R7", busy, 1);
    start_n = 1'b1;
    for (int k = 0; k < 40 && busy; k++) cyc();
    chk(!busy && result == 12'h155, "R7", result, 12'h155);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    run_conv(1, 12'hA5C, 1'b0, 1'b0, 1'b0);
    run_conv(3, 12'h3C1, 1'b0, 1'b1, 1'b0);
    t_bus(12'h3C1);
    cs_n = 1'b0; rd_n = 1'b0;
    run_conv(2, 12'h7E9, 1'b1, 1'b0, 1'b1);
    t_sleep_wake();
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule